// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog

This block is a watchdog timer driven by a slow tick enable (about 760 Hz in a typical system). Software programs it through one 16-bit control word, which holds a 7-bit key, a run command and an 8-bit start count. Once the watchdog is enabled, every later control write must carry the bitwise complement of the key from the last accepted write. A write with any other key is dropped completely. A stray or runaway write is therefore very unlikely to service or disarm the timer.

Expiry happens in two stages. When the main count runs out, the block raises a non-maskable interrupt and loads a short grace count. If the grace count also runs out before a valid write arrives, the block emits a one-cycle system reset request and then returns to its disabled reset state. A status word reports the live count, whether counting is active, and whether the interrupt is pending. Generating the tick and acting on the reset request are left to the surrounding system.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the interrupt and the reset request are low, and both the control readback and the status word read as zero.
- R2: Control word layout: key in bits [15:9], run command in bit 8, start count in bits [7:0]. Reading the control address returns the last accepted control word.
- R3: While the watchdog is enabled (bit 8 of the stored word is 1), a write is accepted only if its key equals the bitwise complement of the stored key. Any other write changes neither the readback nor the status.
- R4: While the watchdog is disabled, a control write is accepted whatever its key.
- R5: A start count of 0 loads 256.
- R6: An accepted write with the run command at 1 loads the count and starts counting; each tick then lowers the count by one. With the command at 0, the write loads the count, stops counting, and later ticks change nothing.
- R7: A tick that arrives while counting with a count of 1 raises the interrupt and loads the grace count (GRACE_TICKS, default 1).
- R8: An accepted write lowers a pending interrupt and restarts the count from the value it carries.
- R9: A tick that arrives during the grace phase with a count of 1 gives a reset request exactly one cycle long. In the same cycle the interrupt drops, and the control word and status return to zero.
- R10: Status layout: bits [8:0] hold the count, bit 9 shows counting is active (running or grace), bit 10 shows the interrupt is pending, and the other bits read zero.
- R11: When an accepted write and a tick fall in the same cycle, the write wins and the tick is lost.
- R12: A write to the status address or to any other address besides the control address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Slow count enable, one cycle per tick |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| nmi_o | output | 1 | Non-maskable interrupt, first-stage expiry |
| sys_rst_req_o | output | 1 | One-cycle system reset request, second-stage expiry |

## Verification
The checker assumes that the tick enable and the write strobe are single-cycle qualifiers that are sampled at the clock edge. It makes no assumption about how far apart ticks are. It also assumes GRACE_TICKS is at least 1. The bench changes every input on the falling edge and holds each strobe for exactly one cycle. In one scenario it raises a tick and a write in the same cycle on purpose, to exercise the priority rule.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int KEY_W      = 7;
  localparam int CNT_FLD_W  = 8;
  localparam int CNT_W      = CNT_FLD_W + 1;
  localparam int CMD_BIT    = CNT_FLD_W;
  localparam int KEY_LSB    = CNT_FLD_W + 1;
  localparam int CTRL_W     = KEY_LSB + KEY_W;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_RUN   = 2'd1,
    WD_GRACE = 2'd2
  } wd_state_e;

  // Zero in the count field selects the full range.
  function automatic logic [CNT_W-1:0] start_count(input logic [CNT_FLD_W-1:0] fld);
    if (fld == '0) return {1'b1, {CNT_FLD_W{1'b0}}};
    return {1'b0, fld};
  endfunction

  // A disabled watchdog takes any key; an enabled one needs the complement.
  function automatic logic key_ok(input logic enabled,
                                  input logic [KEY_W-1:0] stored,
                                  input logic [KEY_W-1:0] fresh);
    return !enabled || (fresh == ~stored);
  endfunction
endpackage

// File: rtl/wdog_keygate.sv
module wdog_keygate
  import wdog_pkg::*;
(
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata,
  input  logic [CTRL_W-1:0] stored,
  output logic              accept
);
  logic              enabled;
  logic [KEY_W-1:0]  stored_key;
  logic [KEY_W-1:0]  fresh_key;

  assign enabled    = stored[CMD_BIT];
  assign stored_key = stored[KEY_LSB +: KEY_W];
  assign fresh_key  = wdata[KEY_LSB +: KEY_W];
  assign accept     = wr_ctrl && key_ok(enabled, stored_key, fresh_key);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int GRACE_TICKS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             accept,
  input  logic             run_cmd,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             nmi,
  output logic             rst_req,
  output logic             expire_first,
  output logic             expire_second
);
  localparam logic [CNT_W-1:0] GRACE_LD = CNT_W'(GRACE_TICKS);

  wd_state_e state;
  logic      last_tick;
  logic      step;

  assign step          = tick_en && !accept;
  assign last_tick     = (count == CNT_W'(1));
  assign expire_first  = step && (state == WD_RUN)   && last_tick;
  assign expire_second = step && (state == WD_GRACE) && last_tick;
  assign running       = (state != WD_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= WD_IDLE;
      count   <= '0;
      nmi     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (accept) begin
        count <= load_val;
        nmi   <= 1'b0;
        state <= run_cmd ? WD_RUN : WD_IDLE;
      end else if (expire_first) begin
        count <= GRACE_LD;
        nmi   <= 1'b1;
        state <= WD_GRACE;
      end else if (expire_second) begin
        count   <= '0;
        nmi     <= 1'b0;
        rst_req <= 1'b1;
        state   <= WD_IDLE;
      end else if (step && running) begin
        count <= count - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CTRL_ADDR   = 'h40,
  parameter int STAT_ADDR   = 'h44,
  parameter int GRACE_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              nmi_o,
  output logic              sys_rst_req_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam int STAT_PAD = 16 - CNT_W - 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_ctrl;
  logic              accept;
  logic [CNT_W-1:0]  count;
  logic              running;
  logic              expire_first;
  logic              expire_second;
  logic [15:0]       stat_word;

  assign wr_ctrl = reg_we && (reg_addr == CTRL_A);

  wdog_keygate u_gate (
    .wr_ctrl (wr_ctrl),
    .wdata   (reg_wdata),
    .stored  (ctrl_q),
    .accept  (accept)
  );

  wdog_counter #(.GRACE_TICKS(GRACE_TICKS)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .accept        (accept),
    .run_cmd       (reg_wdata[CMD_BIT]),
    .load_val      (start_count(reg_wdata[CNT_FLD_W-1:0])),
    .count         (count),
    .running       (running),
    .nmi           (nmi_o),
    .rst_req       (sys_rst_req_o),
    .expire_first  (expire_first),
    .expire_second (expire_second)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             ctrl_q <= '0;
    else if (accept)        ctrl_q <= reg_wdata;
    else if (expire_second) ctrl_q <= '0;
  end

  assign stat_word = {{STAT_PAD{1'b0}}, nmi_o, running, count};

  always_comb begin
    if (reg_addr == CTRL_A)      reg_rdata = ctrl_q;
    else if (reg_addr == STAT_A) reg_rdata = stat_word;
    else                         reg_rdata = '0;
  end
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ctrl,
  input logic              accept,
  input logic [15:0]       reg_wdata,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  count,
  input logic              running,
  input logic              expire_first,
  input logic              expire_second,
  input logic              nmi_o,
  input logic              sys_rst_req_o
);
  AST_BAD_KEY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_q[CMD_BIT] && reg_wdata[KEY_LSB +: KEY_W] != ~ctrl_q[KEY_LSB +: KEY_W]
     && !expire_second) |=> $stable(ctrl_q)); // R3
  AST_ZERO_IS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && reg_wdata[CNT_FLD_W-1:0] == '0) |=> (count == {1'b1, {CNT_FLD_W{1'b0}}})); // R5
  AST_STOPPED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !accept) |=> $stable(count)); // R6
  AST_FIRST_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    expire_first |=> nmi_o); // R7
  AST_WRITE_CLEARS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !nmi_o); // R8
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |=> !sys_rst_req_o); // R9
  AST_RST_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req_o) |-> ($past(nmi_o) && !nmi_o && !running)); // R9
endmodule

bind wdog_keyed wdog_keyed_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_ctrl       (wr_ctrl),
  .accept        (accept),
  .reg_wdata     (reg_wdata),
  .ctrl_q        (ctrl_q),
  .count         (count),
  .running       (running),
  .expire_first  (expire_first),
  .expire_second (expire_second),
  .nmi_o         (nmi_o),
  .sys_rst_req_o (sys_rst_req_o)
);

// File: tb/wdog_keyed_tb_top.sv
`timescale 1ns/1ps
module wdog_keyed_tb_top;
  localparam logic [7:0] A_CTRL  = 8'h40;
  localparam logic [7:0] A_STAT  = 8'h44;
  localparam logic [7:0] A_OTHER = 8'h48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  reg_addr = A_STAT;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        nmi_o;
  logic        sys_rst_req_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  wdog_keyed dut_i (
    .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
    .reg_addr (reg_addr), .reg_we (reg_we), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .nmi_o (nmi_o), .sys_rst_req_o (sys_rst_req_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: run hung, got %0d cycles exp below 100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] cw(input logic [6:0] key, input logic cmd, input logic [7:0] cnt);
    return {key, cmd, cnt};
  endfunction

  function automatic logic [15:0] sw(input logic nmi, input logic run, input logic [8:0] cnt);
    return {5'b0, nmi, run, cnt};
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] a, input logic [15:0] d, input logic tk);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; tick_en = tk;
    @(negedge clk);
    reg_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d); cyc(1'b1, A_CTRL, d, 1'b0); endtask
  task automatic tk(); cyc(1'b0, A_STAT, 16'h0, 1'b1); endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    reg_addr = a; #0.5; v = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(A_CTRL, v); check("R1 ctrl", v, 16'h0);
    rd(A_STAT, v); check("R1 stat", v, 16'h0);
    check("R1 nmi", {15'b0, nmi_o}, 16'h0);
    check("R1 rstreq", {15'b0, sys_rst_req_o}, 16'h0);
  endtask

  task automatic t_keys();
    logic [15:0] v;
    wr(cw(7'h15, 1'b1, 8'd3));                                // R4 disabled, any key
    rd(A_CTRL, v); check("R2 readback", v, 16'h2B03);
    rd(A_STAT, v); check("R10 stat run", v, sw(0, 1, 9'd3));
    wr(cw(7'h15, 1'b1, 8'd5));                                // R3 wrong key
    rd(A_CTRL, v); check("R3 ctrl kept", v, 16'h2B03);
    rd(A_STAT, v); check("R3 stat kept", v, sw(0, 1, 9'd3));
    tk();
    rd(A_STAT, v); check("R6 decrement", v, sw(0, 1, 9'd2));
    wr(cw(7'h6A, 1'b1, 8'd0));                                // R5 complement key, zero count
    rd(A_STAT, v); check("R5 zero is 256", v, sw(0, 1, 9'd256));
    tk();
    rd(A_STAT, v); check("R6 decrement 255", v, sw(0, 1, 9'd255));
  endtask

  task automatic t_stop();
    logic [15:0] v;
    wr(cw(7'h15, 1'b0, 8'd4));
    rd(A_STAT, v); check("R6 stop load", v, sw(0, 0, 9'd4));
    tk(); tk();
    rd(A_STAT, v); check("R6 ticks ignored", v, sw(0, 0, 9'd4));
  endtask

  task automatic t_expire_service();
    logic [15:0] v;
    wr(cw(7'h00, 1'b1, 8'd2));                                // R4 disabled again
    tk();
    check("R7 no nmi yet", {15'b0, nmi_o}, 16'h0);
    tk();
    check("R7 nmi", {15'b0, nmi_o}, 16'h1);
    rd(A_STAT, v); check("R7 grace stat", v, sw(1, 1, 9'd1));
    wr(cw(7'h7F, 1'b1, 8'd2));
    check("R8 nmi low", {15'b0, nmi_o}, 16'h0);
    rd(A_STAT, v); check("R8 restart", v, sw(0, 1, 9'd2));
  endtask

  task automatic t_second_stage();
    logic [15:0] v;
    tk(); tk();
    check("R7 nmi again", {15'b0, nmi_o}, 16'h1);
    check("R9 no req yet", {15'b0, sys_rst_req_o}, 16'h0);
    tk();
    check("R9 req high", {15'b0, sys_rst_req_o}, 16'h1);
    check("R9 nmi dropped", {15'b0, nmi_o}, 16'h0);
    rd(A_STAT, v); check("R9 stat zero", v, 16'h0);
    rd(A_CTRL, v); check("R9 ctrl zero", v, 16'h0);
    @(negedge clk);
    check("R9 one cycle", {15'b0, sys_rst_req_o}, 16'h0);
  endtask

  task automatic t_priority_and_addr();
    logic [15:0] v;
    wr(cw(7'h01, 1'b1, 8'd5));
    cyc(1'b1, A_CTRL, cw(7'h7E, 1'b1, 8'd7), 1'b1);           // R11 write with tick
    rd(A_STAT, v); check("R11 write wins", v, sw(0, 1, 9'd7));
    tk();
    rd(A_STAT, v); check("R11 then ticks", v, sw(0, 1, 9'd6));
    cyc(1'b1, A_STAT, cw(7'h01, 1'b0, 8'd9), 1'b0);          // R12 status address
    cyc(1'b1, A_OTHER, cw(7'h01, 1'b0, 8'd9), 1'b0);         // R12 other address
    rd(A_STAT, v); check("R12 stat unchanged", v, sw(0, 1, 9'd6));
    rd(A_CTRL, v); check("R12 ctrl unchanged", v, cw(7'h7E, 1'b1, 8'd7));
    wr(cw(7'h55, 1'b0, 8'd1));                                // R3 wrong key cannot stop
    tk();
    rd(A_STAT, v); check("R3 still running", v, sw(0, 1, 9'd5));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_keys();
    t_stop();
    t_expire_service();
    t_second_stage();
    t_priority_and_addr();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule